// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

The block holds two timer/counter units. Each unit has a low and a high count byte, a run bit, an overflow flag and a 4-bit mode nibble. The count source is chosen per unit. It is either an internal tick, produced once every `PRESCALE` (default 12) clocks, or a falling edge on the unit's event pin, found by sampling that pin on consecutive ticks. A per-unit gate bit can make counting also depend on a level input.

Two mode bits set how the count bytes are joined. The options are a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads from the high byte, and a split form. In the split form, unit 0 acts as two independent 8-bit counters and takes over unit 1's run bit and flag. The count bytes, the run bits and the mode nibbles are loaded through plain write strobes. A flag is cleared by a software clear strobe or by an acknowledge strobe from interrupt logic. Every wrap of unit 1 also gives a one-cycle pulse for use as a serial baud source.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all count bytes, flags, run bits and mode nibbles are 0, and `baud_pulse` is 0.
- R2: `lo_we[u]`/`hi_we[u]` load `cnt_wd` into that unit's low/high byte. `mode_we` loads `mode_wd[3:0]` into unit 0 and `mode_wd[7:4]` into unit 1. Within each nibble, bit 3 is gate, bit 2 selects event counting and bits 1:0 are the mode (0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split). `run_we` loads `run_wd[u]` into run bit u. A count write cancels that unit's counting step in the same cycle. In split mode the low-byte write cancels only the low counter's step and the high-byte write cancels only the high counter's step.
- R3: In timer mode (event select 0) a running, ungated unit advances exactly once in every `PRESCALE` consecutive clock cycles.
- R4: Mode 0 increments {high byte, low byte bits 4:0} as 13 bits, and low byte bits 7:5 stay unchanged. A wrap from 1FFFh sets the flag.
- R5: Mode 1 increments {high, low} as 16 bits, and the wrap from FFFFh to 0000h sets the flag.
- R6: Mode 2 increments the low byte. When the low byte is FFh, the next step loads the high byte into it and sets the flag, and the high byte is unchanged.
- R7: With unit 0 in mode 3, its low byte is an 8-bit counter under unit 0's controls and its wrap sets flag 0. Its high byte is an 8-bit counter of internal ticks, run by run bit 1 with no gate, and its wrap sets flag 1.
- R8: Unit 1 in mode 3 holds its count. While unit 0 is in mode 3, unit 1 counts whatever the value of run bit 1, and its wraps do not set flag 1.
- R9: In event mode, the event pin is sampled on each internal tick. A sample of 1 followed by a sample of 0 gives exactly one increment.
- R10: With the gate bit set, the unit counts only while its `gate_pin` is 1.
- R11: With its run bit at 0 (and unit 0 not split), a unit holds its count.
- R12: `flag_clr[u]` or `flag_ack[u]` clears flag u on the next edge. A set in the same cycle wins over the clear.
- R13: Each wrap of unit 1 gives `baud_pulse` high for one cycle, in the cycle when the wrapped count becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode nibble write strobe |
| mode_wd | input | 8 | Mode nibbles, unit 1 in the upper half |
| run_we | input | 1 | Run bit write strobe |
| run_wd | input | 2 | Run bits, one per unit |
| lo_we | input | 2 | Low byte write strobes per unit |
| hi_we | input | 2 | High byte write strobes per unit |
| cnt_wd | input | 8 | Data for count byte writes |
| flag_clr | input | 2 | Software flag clear per unit |
| flag_ack | input | 2 | Interrupt acknowledge flag clear per unit |
| evt_pin | input | 2 | External event inputs |
| gate_pin | input | 2 | External gate levels |
| ovf_flag | output | 2 | Overflow flags |
| baud_pulse | output | 1 | One-cycle pulse on each unit 1 wrap |
| cnt0 | output | 16 | Unit 0 count {high, low} |
| cnt1 | output | 16 | Unit 1 count {high, low} |

## Verification
A wrong prescaler phase or width shows up within one `PRESCALE` period, as a count that moves too early or too late compared with the reference model. A wrong byte-joining rule or reload path stays hidden until a wrap, so the directed cases preload counts just below each mode's wrap point and expose the fault within a few ticks, both on the count and on the flag. A stale event-pin sample or a split-mode run-bit mix-up shows in the cycle after the next tick, as an extra or missing increment.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
    localparam int BYTE_W    = 8;
    localparam int NIB_W     = 4;
    localparam int NUM_UNITS = 2;
    localparam int P13_LO_W  = 5;

    typedef enum logic [1:0] {
        MD_P13   = 2'd0,
        MD_W16   = 2'd1,
        MD_RLD8  = 2'd2,
        MD_SPLIT = 2'd3
    } tmode_e;

    typedef struct packed {
        logic   gate;
        logic   use_evt;
        tmode_e mode;
    } mode_nib_t;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t     [NUM_UNITS-1:0] lo;
        byte_t     [NUM_UNITS-1:0] hi;
        logic      [NUM_UNITS-1:0] run;
        mode_nib_t [NUM_UNITS-1:0] mode;
        logic      [NUM_UNITS-1:0] flag;
        logic                      baud;
    } pair_state_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == CW'(DIV - 1));
        st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_evt_qual.sv
module tmr_evt_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic evt_pin,
    input  logic use_evt,
    input  logic gate,
    input  logic gate_pin,
    output logic step_ok
);
    typedef struct packed {
        logic prev;
    } qual_state_t;

    qual_state_t st_d, st_q;
    logic        fall;

    always_comb begin
        st_d      = st_q;
        // falling edge seen between two consecutive tick samples
        fall      = tick & st_q.prev & ~evt_pin;
        st_d.prev = tick ? evt_pin : st_q.prev;
        step_ok   = (use_evt ? fall : tick) & (~gate | gate_pin);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_step.sv
module tmr_step
    import tmr_pair_pkg::*;
#(
    parameter bit ALLOW_SPLIT = 1'b1
) (
    input  tmode_e mode,
    input  byte_t  lo,
    input  byte_t  hi,
    input  logic   inc_main,
    input  logic   inc_hi,
    output byte_t  lo_n,
    output byte_t  hi_n,
    output logic   ovf_main,
    output logic   ovf_hi
);
    always_comb begin
        lo_n     = lo;
        hi_n     = hi;
        ovf_main = 1'b0;
        ovf_hi   = 1'b0;
        unique case (mode)
            MD_P13: if (inc_main) begin
                ovf_main = &{hi, lo[P13_LO_W-1:0]};
                {hi_n, lo_n[P13_LO_W-1:0]} = {hi, lo[P13_LO_W-1:0]} + 1'b1;
            end
            MD_W16: if (inc_main) begin
                ovf_main     = &{hi, lo};
                {hi_n, lo_n} = {hi, lo} + 1'b1;
            end
            MD_RLD8: if (inc_main) begin
                ovf_main = &lo;
                lo_n     = (&lo) ? hi : lo + 1'b1;
            end
            MD_SPLIT: if (ALLOW_SPLIT) begin
                if (inc_main) begin
                    ovf_main = &lo;
                    lo_n     = lo + 1'b1;
                end
                if (inc_hi) begin
                    ovf_hi = &hi;
                    hi_n   = hi + 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pair_pkg::*;
#(
    parameter int PRESCALE = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_we,
    input  logic [NUM_UNITS*NIB_W-1:0] mode_wd,
    input  logic                      run_we,
    input  logic [NUM_UNITS-1:0]      run_wd,
    input  logic [NUM_UNITS-1:0]      lo_we,
    input  logic [NUM_UNITS-1:0]      hi_we,
    input  logic [BYTE_W-1:0]         cnt_wd,
    input  logic [NUM_UNITS-1:0]      flag_clr,
    input  logic [NUM_UNITS-1:0]      flag_ack,
    input  logic [NUM_UNITS-1:0]      evt_pin,
    input  logic [NUM_UNITS-1:0]      gate_pin,
    output logic [NUM_UNITS-1:0]      ovf_flag,
    output logic                      baud_pulse,
    output logic [2*BYTE_W-1:0]       cnt0,
    output logic [2*BYTE_W-1:0]       cnt1
);
    pair_state_t st_d, st_q;

    logic                          tick;
    logic                          split0;
    tmode_e [NUM_UNITS-1:0]        unit_mode;
    logic   [NUM_UNITS-1:0]        run_bits;
    logic   [NUM_UNITS-1:0]        qual;
    logic   [NUM_UNITS-1:0]        inc_main;
    logic   [NUM_UNITS-1:0]        inc_hi;
    logic   [NUM_UNITS-1:0]        ovf_m;
    logic   [NUM_UNITS-1:0]        ovf_h;
    logic   [NUM_UNITS-1:0]        flag_set;
    byte_t  [NUM_UNITS-1:0]        lo_n;
    byte_t  [NUM_UNITS-1:0]        hi_n;

    tmr_prescale #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) unit_mode[u] = st_q.mode[u].mode;
        run_bits = st_q.run;
        split0   = (unit_mode[0] == MD_SPLIT);
    end

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            tmr_evt_qual u_qual (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .evt_pin (evt_pin[u]),
                .use_evt (st_q.mode[u].use_evt),
                .gate    (st_q.mode[u].gate),
                .gate_pin(gate_pin[u]),
                .step_ok (qual[u])
            );
            // only the first unit may split; the second parks in mode 3
            tmr_step #(.ALLOW_SPLIT(u == 0)) u_step (
                .mode    (unit_mode[u]),
                .lo      (st_q.lo[u]),
                .hi      (st_q.hi[u]),
                .inc_main(inc_main[u]),
                .inc_hi  (inc_hi[u]),
                .lo_n    (lo_n[u]),
                .hi_n    (hi_n[u]),
                .ovf_main(ovf_m[u]),
                .ovf_hi  (ovf_h[u])
            );
        end
    endgenerate

    always_comb begin
        // unit 0: in split form a write cancels only the counter it hits
        inc_main[0] = qual[0] & run_bits[0]
                    & ~(split0 ? lo_we[0] : (lo_we[0] | hi_we[0]));
        inc_hi[0]   = tick & run_bits[1] & split0 & ~hi_we[0];
        // unit 1: free of its run bit while unit 0 borrows it
        inc_main[1] = qual[1] & (run_bits[1] | split0) & ~(lo_we[1] | hi_we[1]);
        inc_hi[1]   = 1'b0;
    end

    always_comb begin
        st_d        = st_q;
        flag_set[0] = ovf_m[0];
        // ovf_h[1] is constant 0; kept in the OR so every output is consumed
        flag_set[1] = split0 ? ovf_h[0] : (ovf_m[1] | ovf_h[1]);
        for (int u = 0; u < NUM_UNITS; u++) begin
            st_d.lo[u]   = lo_we[u] ? cnt_wd : lo_n[u];
            st_d.hi[u]   = hi_we[u] ? cnt_wd : hi_n[u];
            st_d.flag[u] = (st_q.flag[u] & ~(flag_clr[u] | flag_ack[u])) | flag_set[u];
            if (mode_we) st_d.mode[u] = mode_nib_t'(mode_wd[u*NIB_W +: NIB_W]);
        end
        if (run_we) st_d.run = run_wd;
        st_d.baud = ovf_m[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_flag   = st_q.flag;
    assign baud_pulse = st_q.baud;
    assign cnt0       = {st_q.hi[0], st_q.lo[0]};
    assign cnt1       = {st_q.hi[1], st_q.lo[1]};
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
    import tmr_pair_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  lo_we,
    input logic [1:0]  hi_we,
    input logic [1:0]  flag_clr,
    input logic [1:0]  flag_ack,
    input logic [1:0]  run_bits,
    input logic [1:0]  flag_set,
    input logic [3:0]  unit_mode,
    input logic [15:0] cnt0,
    input logic [15:0] cnt1,
    input logic [1:0]  ovf_flag,
    input logic        baud_pulse
);
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_bits[0] && unit_mode[1:0] != MD_SPLIT && !lo_we[0] && !hi_we[0]) |=> $stable(cnt0))
        else $error("run hold violated"); // R11

    AST_UNIT1_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_mode[3:2] == MD_SPLIT && !lo_we[1] && !hi_we[1]) |=> $stable(cnt1))
        else $error("parked unit moved"); // R8

    AST_FLAG_CLEAR0: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_clr[0] || flag_ack[0]) && !flag_set[0]) |=> !ovf_flag[0])
        else $error("flag 0 not cleared"); // R12

    AST_FLAG_CLEAR1: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_clr[1] || flag_ack[1]) && !flag_set[1]) |=> !ovf_flag[1])
        else $error("flag 1 not cleared"); // R12

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[1] |=> ovf_flag[1])
        else $error("flag set lost"); // R12

    AST_BAUD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        baud_pulse |=> !baud_pulse)
        else $error("baud pulse too long"); // R13

    AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovf_flag[0]) && $past(unit_mode[1:0]) == MD_RLD8) |-> (cnt0[7:0] == cnt0[15:8]))
        else $error("reload value wrong"); // R6
endmodule

bind tmr_pair tmr_pair_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_we     (lo_we),
    .hi_we     (hi_we),
    .flag_clr  (flag_clr),
    .flag_ack  (flag_ack),
    .run_bits  (run_bits),
    .flag_set  (flag_set),
    .unit_mode (unit_mode),
    .cnt0      (cnt0),
    .cnt1      (cnt1),
    .ovf_flag  (ovf_flag),
    .baud_pulse(baud_pulse)
);

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
    localparam int CLK_PERIOD = 10;
    localparam int PRESC      = 12;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [7:0] mode_wd = '0;
    logic       run_we = 1'b0;
    logic [1:0] run_wd = '0;
    logic [1:0] lo_we = '0, hi_we = '0;
    logic [7:0] cnt_wd = '0;
    logic [1:0] flag_clr = '0, flag_ack = '0;
    logic [1:0] evt_pin = '0, gate_pin = '0;
    logic [1:0] ovf_flag;
    logic       baud_pulse;
    logic [15:0] cnt0, cnt1;

    int    n_checks = 0;
    int    n_errors = 0;
    string phase_tag = "R1";
    bit    mon_en = 1'b0;
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_pair #(.PRESCALE(PRESC)) dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wd(mode_wd),
        .run_we(run_we), .run_wd(run_wd), .lo_we(lo_we), .hi_we(hi_we),
        .cnt_wd(cnt_wd), .flag_clr(flag_clr), .flag_ack(flag_ack),
        .evt_pin(evt_pin), .gate_pin(gate_pin), .ovf_flag(ovf_flag),
        .baud_pulse(baud_pulse), .cnt0(cnt0), .cnt1(cnt1)
    );

    // ---------------- reference model built from the requirements ----------
    int         m_pre;
    logic [1:0][7:0] m_lo, m_hi;
    logic [1:0][3:0] m_mode;
    logic [1:0] m_run, m_flag, m_prev, m_q, m_set;
    logic       m_baud;
    logic       m_tk, m_ed, m_sp, m_im0, m_ih0, m_im1, m_o0, m_oh0, m_o1, m_ox;
    logic [7:0] l0, h0, l1, h1;

    function automatic void ref_step(input bit split_ok, input logic [1:0] md,
                                     inout logic [7:0] lo, inout logic [7:0] hi,
                                     input logic inc_m, input logic inc_h,
                                     output logic om, output logic oh);
        om = 1'b0;
        oh = 1'b0;
        case (md)
            2'd0: if (inc_m) begin
                om = ({hi, lo[4:0]} == 13'h1FFF);
                {hi, lo[4:0]} = {hi, lo[4:0]} + 13'd1;
            end
            2'd1: if (inc_m) begin
                om = ({hi, lo} == 16'hFFFF);
                {hi, lo} = {hi, lo} + 16'd1;
            end
            2'd2: if (inc_m) begin
                om = (lo == 8'hFF);
                lo = om ? hi : lo + 8'd1;
            end
            default: if (split_ok) begin
                if (inc_m) begin om = (lo == 8'hFF); lo = lo + 8'd1; end
                if (inc_h) begin oh = (hi == 8'hFF); hi = hi + 8'd1; end
            end
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_lo = '0; m_hi = '0; m_mode = '0; m_run = '0;
            m_flag = '0; m_prev = '0; m_baud = 1'b0;
        end else begin
            m_tk  = (m_pre == PRESC - 1);
            m_pre = m_tk ? 0 : m_pre + 1;
            for (int u = 0; u < 2; u++) begin
                m_ed = m_tk && m_prev[u] && !evt_pin[u];
                if (m_tk) m_prev[u] = evt_pin[u];
                m_q[u] = (m_mode[u][2] ? m_ed : m_tk) && (!m_mode[u][3] || gate_pin[u]);
            end
            m_sp  = (m_mode[0][1:0] == 2'd3);
            m_im0 = m_q[0] && m_run[0] && !(m_sp ? lo_we[0] : (lo_we[0] || hi_we[0]));
            m_ih0 = m_tk && m_run[1] && m_sp && !hi_we[0];
            m_im1 = m_q[1] && (m_run[1] || m_sp) && !(lo_we[1] || hi_we[1]);
            l0 = m_lo[0]; h0 = m_hi[0]; l1 = m_lo[1]; h1 = m_hi[1];
            ref_step(1'b1, m_mode[0][1:0], l0, h0, m_im0, m_ih0, m_o0, m_oh0);
            ref_step(1'b0, m_mode[1][1:0], l1, h1, m_im1, 1'b0, m_o1, m_ox);
            m_lo[0] = lo_we[0] ? cnt_wd : l0;
            m_hi[0] = hi_we[0] ? cnt_wd : h0;
            m_lo[1] = lo_we[1] ? cnt_wd : l1;
            m_hi[1] = hi_we[1] ? cnt_wd : h1;
            m_set[0] = m_o0;
            m_set[1] = m_sp ? m_oh0 : m_o1;
            for (int u = 0; u < 2; u++)
                m_flag[u] = (m_flag[u] && !(flag_clr[u] || flag_ack[u])) || m_set[u];
            m_baud = m_o1;
            if (mode_we) m_mode = {mode_wd[7:4], mode_wd[3:0]};
            if (run_we)  m_run = run_wd;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mon_en)
            check({phase_tag, " model"}, {29'd0, cnt0, cnt1, ovf_flag, baud_pulse},
                  {29'd0, m_hi[0], m_lo[0], m_hi[1], m_lo[1], m_flag, m_baud});
    end

    // ---------------- stimulus helpers (start and end at a negedge) -------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic put_mode(input logic [7:0] m);
        mode_we = 1'b1; mode_wd = m; cyc(1); mode_we = 1'b0;
    endtask
    task automatic put_run(input logic [1:0] r);
        run_we = 1'b1; run_wd = r; cyc(1); run_we = 1'b0;
    endtask
    task automatic put_lo(input int u, input logic [7:0] v);
        lo_we[u] = 1'b1; cnt_wd = v; cyc(1); lo_we = '0;
    endtask
    task automatic put_hi(input int u, input logic [7:0] v);
        hi_we[u] = 1'b1; cnt_wd = v; cyc(1); hi_we = '0;
    endtask
    task automatic pulse_clr(input logic [1:0] m);
        flag_clr = m; cyc(1); flag_clr = '0;
    endtask
    task automatic pulse_ack(input logic [1:0] m);
        flag_ack = m; cyc(1); flag_ack = '0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        int npulse;
        void'($urandom(32'd20240611));
        cyc(3);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // R1: reset state
        phase_tag = "R1";
        check("R1 cnt0", cnt0, 16'h0000);
        check("R1 cnt1", cnt1, 16'h0000);
        check("R1 flags", ovf_flag, 2'b00);
        check("R1 baud", baud_pulse, 1'b0);

        // R2 / R11: loads while stopped, then holding
        phase_tag = "R2";
        put_mode(8'h01);
        put_lo(0, 8'h34);
        put_hi(0, 8'h12);
        check("R2 load", cnt0, 16'h1234);
        phase_tag = "R11";
        cyc(60);
        check("R11 hold", cnt0, 16'h1234);

        // R3: exactly one step per PRESCALE clocks
        phase_tag = "R3";
        put_run(2'b01);
        a = cnt0;
        cyc(10 * PRESC);
        check("R3 rate", cnt0, a + 16'd10);

        // R5: 16-bit wrap
        phase_tag = "R5";
        put_run(2'b00);
        put_lo(0, 8'hFD);
        put_hi(0, 8'hFF);
        put_run(2'b01);
        cyc(3 * PRESC);
        check("R5 wrap", cnt0, 16'h0000);
        check("R5 flag", ovf_flag[0], 1'b1);
        phase_tag = "R12";
        pulse_clr(2'b01);
        check("R12 clr", ovf_flag[0], 1'b0);

        // R4: 13-bit wrap keeps low byte bits 7:5
        phase_tag = "R4";
        put_run(2'b00);
        put_mode(8'h00);
        put_lo(0, 8'hFF);
        put_hi(0, 8'hFF);
        put_run(2'b01);
        cyc(PRESC);
        check("R4 wrap", cnt0, 16'h00E0);
        check("R4 flag", ovf_flag[0], 1'b1);
        phase_tag = "R12";
        pulse_ack(2'b01);
        check("R12 ack", ovf_flag[0], 1'b0);

        // R6: reload from high byte
        phase_tag = "R6";
        put_run(2'b00);
        put_mode(8'h02);
        put_lo(0, 8'hFE);
        put_hi(0, 8'h80);
        put_run(2'b01);
        cyc(PRESC);
        check("R6 pre", cnt0, 16'h80FF);
        check("R6 noflag", ovf_flag[0], 1'b0);
        cyc(PRESC);
        check("R6 reload", cnt0, 16'h8080);
        check("R6 flag", ovf_flag[0], 1'b1);
        cyc(PRESC);
        check("R6 resume", cnt0, 16'h8081);
        put_run(2'b00);
        pulse_clr(2'b01);

        // R7: split unit 0
        phase_tag = "R7";
        put_mode(8'h03);
        put_lo(0, 8'hFF);
        put_hi(0, 8'hFE);
        put_run(2'b11);
        cyc(PRESC);
        check("R7 low wrap", cnt0, 16'hFF00);
        check("R7 flags a", ovf_flag, 2'b01);
        cyc(PRESC);
        check("R7 high wrap", cnt0, 16'h0001);
        check("R7 flags b", ovf_flag, 2'b11);

        // R8: unit 1 ignores its run bit while unit 0 is split
        phase_tag = "R8";
        put_run(2'b00);
        a = cnt1;
        cyc(2 * PRESC);
        check("R8 borrowed run", cnt1, a + 16'd2);

        // R13: baud pulses from unit 1 wraps, flag 1 untouched
        phase_tag = "R13";
        pulse_clr(2'b11);
        put_mode(8'h23);
        put_lo(1, 8'hFF);
        put_hi(1, 8'hFF);
        npulse = 0;
        for (int i = 0; i < 4 * PRESC; i++) begin
            cyc(1);
            if (baud_pulse) npulse++;
        end
        check("R13 pulses", npulse, 4);
        check("R8 no flag1", ovf_flag, 2'b00);

        // R8: unit 1 parked in mode 3
        phase_tag = "R8";
        put_mode(8'h31);
        put_run(2'b11);
        a = cnt1;
        npulse = 0;
        for (int i = 0; i < 4 * PRESC; i++) begin
            cyc(1);
            if (baud_pulse) npulse++;
        end
        check("R8 parked", cnt1, a);
        check("R8 parked baud", npulse, 0);

        // R9: event counting
        phase_tag = "R9";
        put_run(2'b00);
        put_mode(8'h05);
        put_lo(0, 8'h00);
        put_hi(0, 8'h00);
        put_run(2'b01);
        for (int i = 0; i < 5; i++) begin
            evt_pin[0] = 1'b1; cyc(2 * PRESC);
            evt_pin[0] = 1'b0; cyc(2 * PRESC);
        end
        check("R9 events", cnt0, 16'd5);

        // R10: gate
        phase_tag = "R10";
        put_run(2'b00);
        put_mode(8'h09);
        put_lo(0, 8'h00);
        gate_pin[0] = 1'b0;
        put_run(2'b01);
        cyc(4 * PRESC);
        check("R10 gated", cnt0, 16'd0);
        gate_pin[0] = 1'b1;
        cyc(4 * PRESC);
        check("R10 open", cnt0, 16'd4);

        // constrained random run checked against the model
        phase_tag = "RND";
        for (int i = 0; i < 4000; i++) begin
            mode_we  = ($urandom_range(0, 47) == 0);
            mode_wd  = 8'($urandom);
            run_we   = ($urandom_range(0, 31) == 0);
            run_wd   = 2'($urandom);
            lo_we    = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00;
            hi_we    = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00;
            cnt_wd   = ($urandom_range(0, 1) == 1) ? (8'hF8 | 8'($urandom_range(0, 7))) : 8'($urandom);
            flag_clr = ($urandom_range(0, 19) == 0) ? 2'($urandom) : 2'b00;
            flag_ack = ($urandom_range(0, 19) == 0) ? 2'($urandom) : 2'b00;
            if ($urandom_range(0, 9) == 0) evt_pin = evt_pin ^ 2'($urandom_range(1, 3));
            if ($urandom_range(0, 63) == 0) gate_pin = 2'($urandom);
            cyc(1);
        end
        mode_we = 1'b0; run_we = 1'b0; lo_we = '0; hi_we = '0;
        flag_clr = '0; flag_ack = '0;
        cyc(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule